// File: doc/BRIEF.md
# Single-to-Double Float Widening Converter

This block takes one IEEE-754 binary32 number from the bottom word of a 128-bit source vector, converts it to binary64 and places the result in the low 64-bit lane of a 128-bit destination vector. The upper lane of the destination is passed through from the destination operand the caller supplies. Every binary32 value can be represented exactly in binary64, so the conversion never rounds and never raises a precision flag. It reports two status conditions. One marks an invalid operation, caused by a signaling NaN. The other marks a denormal operand.

The block sorts the input into one of six classes: zero, denormal, normal, infinity, quiet NaN or signaling NaN. A denormal input is shifted so that its leading one becomes the hidden bit, and the exponent is adjusted to match. A signaling NaN is made quiet. A control input, the flush-denormals switch, makes a denormal input read as a zero of the same sign. By default the result and the flags are registered once, with a valid strobe beside them. A parameter selects a purely combinational variant instead.

Top module: `f2d_widen_top`

## Requirements
- R1: When `res_valid_o` is high, `res_o[127:64]` equals `dst_i[127:64]` sampled on the accepted cycle.
- R2: Source bits [127:32] have no effect on the result or the flags. Only `src_i[31:0]` is converted, using sign at bit 31, exponent at bits 30:23 and fraction at bits 22:0.
- R3: A normal input keeps its sign. Its 8-bit exponent is rebiased by adding 896. Its 23-bit fraction fills the top of the 52-bit fraction, and the remaining 29 low bits are zero.
- R4: A zero or infinite input keeps its sign. A zero becomes all-zero exponent and fraction. An infinity becomes exponent 0x7FF with a zero fraction.
- R5: A quiet NaN, meaning exponent 0xFF with fraction bit 22 set, is widened with its sign and payload moved up by 29 bits. It does not raise `inv_o`.
- R6: A signaling NaN, meaning exponent 0xFF with bit 22 clear and a nonzero fraction, gives a quiet NaN. The sign is kept, fraction bit 51 is set, fraction bits 21:0 move to bits 50:29, and `inv_o` is raised.
- R7: A denormal input with `daz_i` low is normalised exactly. With leading one at fraction bit p, the exponent is 874+p and the bits below p fill the top of the fraction. `den_o` is raised.
- R8: A denormal input with `daz_i` high gives a zero of the same sign and raises `den_o`.
- R9: `inv_o` is raised only for a signaling NaN and `den_o` only for a denormal. The two are never high together.
- R10: With the registered variant, `res_valid_o` follows `valid_i` one cycle later. Result and flags load only on cycles where `valid_i` is high and hold otherwise. Reset clears valid, flags and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present this cycle |
| src_i | input | 128 | Source vector; low 32 bits converted |
| dst_i | input | 128 | Destination vector; upper lane passed through |
| daz_i | input | 1 | Treat denormal inputs as zero |
| res_o | output | 128 | Merged result vector |
| res_valid_o | output | 1 | Result valid |
| inv_o | output | 1 | Invalid-operation status (signaling NaN) |
| den_o | output | 1 | Denormal-operand status |

## Verification
The assertions take it that `dst_i` and `daz_i` come from the same cycle as the accepted `valid_i`. They also take it that the registered variant is in use, because every property reads the input one cycle before the output. The stimulus picks the input class first and then fills in the exponent and fraction inside that class. This places signaling and quiet NaNs, denormals and both signs at known rates, so the classes are not left to chance in raw 32-bit random words. The upper source bits are filled with random values throughout, and directed cases check that changing them leaves the result the same.

// File: rtl/f2d_pkg.sv
package f2d_pkg;
   localparam int SP_W      = 32;
   localparam int SP_EXP_W  = 8;
   localparam int SP_MAN_W  = 23;
   localparam int DP_W      = 64;
   localparam int DP_EXP_W  = 11;
   localparam int DP_MAN_W  = 52;
   localparam int MAN_PAD   = DP_MAN_W - SP_MAN_W;
   localparam int BIAS_DIFF = 1023 - 127;
   localparam int DEN_BASE  = BIAS_DIFF - 126 - SP_MAN_W + 127;

   typedef enum logic [2:0] {
      FC_ZERO, FC_DENORM, FC_NORMAL, FC_INF, FC_QNAN, FC_SNAN
   } fcls_e;

   typedef struct packed {
      logic            sign;
      logic [SP_EXP_W-1:0] exp;
      logic [SP_MAN_W-1:0] man;
   } sp_t;

   typedef struct packed {
      logic            sign;
      logic [DP_EXP_W-1:0] exp;
      logic [DP_MAN_W-1:0] man;
   } dp_t;
endpackage

// File: rtl/f2d_classify.sv
module f2d_classify
   import f2d_pkg::*;
(
   input  sp_t   op_i,
   output fcls_e cls_o
);
   logic exp_max, exp_min, man_nz;
   assign exp_max = &op_i.exp;
   assign exp_min = ~|op_i.exp;
   assign man_nz  = |op_i.man;

   always_comb begin
      if (exp_min)      cls_o = man_nz ? FC_DENORM : FC_ZERO;
      else if (!exp_max) cls_o = FC_NORMAL;
      else if (!man_nz)  cls_o = FC_INF;
      else if (op_i.man[SP_MAN_W-1]) cls_o = FC_QNAN;
      else               cls_o = FC_SNAN;
   end

   always_comb begin
      if (cls_o == FC_SNAN)
         assert_snan_shape_R6: assert (exp_max && !op_i.man[SP_MAN_W-1]);
   end
endmodule

// File: rtl/f2d_widen.sv
module f2d_widen
   import f2d_pkg::*;
(
   input  sp_t   op_i,
   input  fcls_e cls_i,
   input  logic  daz_i,
   output dp_t   res_o,
   output logic  inv_o,
   output logic  den_o
);
   localparam int POS_W = $clog2(SP_MAN_W);
   localparam int SH_W  = $clog2(DP_MAN_W + 1);

   logic [POS_W-1:0]    lead_pos;
   logic [DP_MAN_W-1:0] norm_man;
   logic [DP_EXP_W-1:0] norm_exp;

   always_comb begin
      lead_pos = '0;
      for (int i = 0; i < SP_MAN_W; i++)
         if (op_i.man[i]) lead_pos = POS_W'(i);
   end

   assign norm_man = DP_MAN_W'({{MAN_PAD{1'b0}}, op_i.man} << (SH_W'(DP_MAN_W) - SH_W'(lead_pos)));
   assign norm_exp = DP_EXP_W'(lead_pos) + DP_EXP_W'(DEN_BASE);

   always_comb begin
      res_o.sign = op_i.sign;
      res_o.exp  = '0;
      res_o.man  = '0;
      inv_o      = 1'b0;
      den_o      = 1'b0;
      unique case (cls_i)
         FC_ZERO: ;
         FC_DENORM: begin
            den_o = 1'b1;
            if (!daz_i) begin
               res_o.exp = norm_exp;
               res_o.man = norm_man;
            end
         end
         FC_NORMAL: begin
            res_o.exp = DP_EXP_W'(op_i.exp) + DP_EXP_W'(BIAS_DIFF);
            res_o.man = {op_i.man, {MAN_PAD{1'b0}}};
         end
         FC_INF: res_o.exp = '1;
         FC_QNAN: begin
            res_o.exp = '1;
            res_o.man = {op_i.man, {MAN_PAD{1'b0}}};
         end
         FC_SNAN: begin
            inv_o     = 1'b1;
            res_o.exp = '1;
            res_o.man = {1'b1, op_i.man[SP_MAN_W-2:0], {MAN_PAD{1'b0}}};
         end
         default: ;
      endcase
   end

   always_comb begin
      if (cls_i == FC_DENORM && !daz_i)
         assert_norm_hidden_R7: assert (op_i.man[lead_pos] && (op_i.man >> lead_pos) == 1);
   end
endmodule

// File: rtl/f2d_merge.sv
module f2d_merge #(
   parameter int VEC_W  = 128,
   parameter int LANE_W = 64
) (
   input  logic [LANE_W-1:0] lane_i,
   input  logic [VEC_W-1:0]  dst_i,
   output logic [VEC_W-1:0]  vec_o
);
   localparam int HI_W = VEC_W - LANE_W;

   if (LANE_W > VEC_W) begin : g_bad
      $error("f2d_merge: lane wider than vector");
   end

   assign vec_o[LANE_W-1:0] = lane_i;

   if (HI_W > 0) begin : g_hi
      assign vec_o[VEC_W-1:LANE_W] = dst_i[VEC_W-1:LANE_W];
      logic unused_dst_lo;
      assign unused_dst_lo = ^dst_i[LANE_W-1:0];
   end else begin : g_nohi
      logic unused_dst;
      assign unused_dst = ^dst_i;
   end
endmodule

// File: rtl/f2d_widen_top.sv
module f2d_widen_top
   import f2d_pkg::*;
#(
   parameter int VEC_W   = 128,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             valid_i,
   input  logic [VEC_W-1:0] src_i,
   input  logic [VEC_W-1:0] dst_i,
   input  logic             daz_i,
   output logic [VEC_W-1:0] res_o,
   output logic             res_valid_o,
   output logic             inv_o,
   output logic             den_o
);
   if (VEC_W < DP_W || (VEC_W % SP_W) != 0) begin : g_chk
      $error("f2d_widen_top: VEC_W must be a multiple of 32 and at least 64");
   end

   sp_t        sp;
   fcls_e      cls;
   dp_t        dp;
   logic       inv_c, den_c;
   logic [VEC_W-1:0] vec_c;
   logic       unused_src_hi;

   assign sp            = src_i[SP_W-1:0];
   assign unused_src_hi = ^src_i[VEC_W-1:SP_W];

   f2d_classify u_cls (.op_i(sp), .cls_o(cls));

   f2d_widen u_wid (
      .op_i(sp), .cls_i(cls), .daz_i(daz_i),
      .res_o(dp), .inv_o(inv_c), .den_o(den_c)
   );

   f2d_merge #(.VEC_W(VEC_W), .LANE_W(DP_W)) u_mrg (
      .lane_i(dp), .dst_i(dst_i), .vec_o(vec_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            res_o       <= '0;
            res_valid_o <= 1'b0;
            inv_o       <= 1'b0;
            den_o       <= 1'b0;
         end else begin
            res_valid_o <= valid_i;
            if (valid_i) begin
               res_o <= vec_c;
               inv_o <= inv_c;
               den_o <= den_c;
            end
         end
      end

      assert_upper_keep_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
         res_valid_o |-> res_o[VEC_W-1:DP_W] == $past(dst_i[VEC_W-1:DP_W]));
      assert_valid_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_i |=> res_valid_o);
      assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !valid_i |=> !res_valid_o && $stable(res_o) && $stable(inv_o));
      assert_flag_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !(inv_o && den_o));
      assert_inv_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         res_valid_o && inv_o |-> res_o[62:51] == 12'hFFF);
      assert_daz_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         res_valid_o && den_o && $past(daz_i) |-> res_o[62:0] == 63'd0);
   end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl  = clk_i ^ rst_ni;
      assign res_o       = vec_c;
      assign res_valid_o = valid_i;
      assign inv_o       = inv_c;
      assign den_o       = den_c;
   end
endmodule

// File: tb/f2d_widen_top_tb_top.sv
module f2d_widen_top_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid = 1'b0;
   logic [127:0] src = '0, dst = '0;
   logic         daz = 1'b0;
   logic [127:0] res;
   logic         rvalid, inv, den;
   int           n_chk = 0, n_fail = 0;
   bit           done = 1'b0;

   always #4 clk = ~clk;

   f2d_widen_top dut_i (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .src_i(src), .dst_i(dst),
      .daz_i(daz), .res_o(res), .res_valid_o(rvalid), .inv_o(inv), .den_o(den)
   );

   function automatic logic [65:0] model(input logic [31:0] s, input logic dz);
      logic sg; logic [7:0] e; logic [22:0] m; logic [23:0] mm;
      logic [63:0] r; logic fi, fd; int k;
      sg = s[31]; e = s[30:23]; m = s[22:0];
      fi = 0; fd = 0; r = {sg, 63'd0};
      if (e == 0) begin
         if (m != 0) begin
            fd = 1;
            if (!dz) begin
               mm = {1'b0, m}; k = 0;
               while (!mm[23]) begin mm = mm << 1; k++; end
               r = {sg, 11'(897 - k), mm[22:0], 29'd0};
            end
         end
      end else if (e == 8'hFF) begin
         if (m == 0) r = {sg, 11'h7FF, 52'd0};
         else if (m[22]) r = {sg, 11'h7FF, m, 29'd0};
         else begin fi = 1; r = {sg, 11'h7FF, 1'b1, m[21:0], 29'd0}; end
      end else r = {sg, 11'(e) + 11'd896, m, 29'd0};
      return {fi, fd, r};
   endfunction

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input string req, input logic [31:0] s, input logic [95:0] hi,
                      input logic [127:0] d, input logic dz);
      logic [65:0] e;
      @(negedge clk);
      src = {hi, s}; dst = d; daz = dz; valid = 1'b1;
      @(negedge clk);
      valid = 1'b0;
      e = model(s, dz);
      check(req, {res[63:0]}, {64'd0, e[63:0]});
      check({req, " upper lane R1"}, {64'd0, res[127:64]}, {64'd0, d[127:64]});
      check({req, " flags R9"}, {126'd0, inv, den}, {126'd0, e[65:64]});
      check({req, " valid R10"}, {127'd0, rvalid}, 128'd1);
   endtask

   function automatic logic [31:0] gen(input int c);
      logic [31:0] r;
      r = $urandom;
      case (c)
         0: r[30:0] = '0;
         1: begin r[30:23] = 0; if (r[22:0] == 0) r[0] = 1; end
         2: if (r[30:23] == 0 || r[30:23] == 8'hFF) r[30:23] = 8'h40;
         3: begin r[30:23] = 8'hFF; r[22:0] = 0; end
         4: begin r[30:23] = 8'hFF; r[22] = 1; end
         default: begin r[30:23] = 8'hFF; r[22] = 0; if (r[21:0] == 0) r[3] = 1; end
      endcase
      return r;
   endfunction

   initial begin
      logic [127:0] keep;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check("reset R10", {125'd0, rvalid, inv, den}, 128'd0);
      check("reset result R10", res, 128'd0);
      rst_n = 1'b1;
      run("normal R3", 32'h3F80_0000, 96'd0, {64'hDEAD_BEEF_0123_4567, 64'h0}, 0);
      check("normal value R3", {64'd0, res[63:0]}, {64'd0, 64'h3FF0_0000_0000_0000});
      run("neg zero R4", 32'h8000_0000, 96'd5, '1, 0);
      run("neg inf R4", 32'hFF80_0000, 96'd0, '0, 0);
      run("qnan R5", 32'h7FC0_0001, 96'd0, '0, 0);
      run("snan R6", 32'h7F80_0001, 96'd0, '0, 0);
      check("snan value R6", {64'd0, res[63:0]}, {64'd0, 64'h7FF8_0000_2000_0000});
      run("min denorm R7", 32'h0000_0001, 96'd0, '0, 0);
      check("min denorm value R7", {64'd0, res[63:0]}, {64'd0, 64'h36A0_0000_0000_0000});
      run("max denorm R7", 32'h807F_FFFF, 96'd0, '0, 0);
      run("daz denorm R8", 32'h8000_0001, 96'd0, '0, 1);
      check("daz value R8", {64'd0, res[63:0]}, {64'd0, 64'h8000_0000_0000_0000});
      run("daz normal R8", 32'h4049_0FDB, 96'd0, '0, 1);
      run("hi bits R2", 32'h4049_0FDB, {3{32'hFFFF_FFFF}}, '0, 0);
      keep = res;
      run("hi bits R2", 32'h4049_0FDB, 96'h1234_5678_9ABC, '0, 0);
      check("hi bits ignored R2", res, keep);
      repeat (2) @(negedge clk);
      check("idle hold R10", {res, 1'b0}, {keep, rvalid});
      for (int i = 0; i < 400; i++) begin
         int c;
         c = int'($urandom % 6);
         run(c == 5 ? "rand R6" : c == 1 ? "rand R7" : "rand R3", gen(c),
             {$urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
             1'($urandom));
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin repeat (50000) @(posedge clk); n_chk++; n_fail++;
            $display("FAIL watchdog R10 actual=hung expected=done"); end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule